// File: doc/BRIEF.md
# Read-Pattern Command Unlock Detector

This block watches a cycle-based model of an asynchronous SRAM host bus and decodes two hidden commands from it. The host unlocks a command by performing six chip-select-qualified reads in a row. The first five reads go to a fixed prefix of magic addresses. The address of the sixth read chooses the command. One sixth address issues a save command, which would copy volatile contents to the nonvolatile shadow. The other issues a restore command, which would copy the shadow back. Each command leaves the block as a one-cycle pulse. The block moves no data itself; a separate controller acts on the pulses.

Every bus signal is modelled active high. `bus_sel` is chip select, `bus_we` marks a write and `bus_oe` is output drive. An access counts only in a cycle where `bus_stb` is high. A write, or a read to any address other than the expected next one, breaks the pattern. A break sends the detector back to the start, but the breaking read is itself checked as a possible first step. While `busy` is high, for example during a save or restore, all bus activity is disregarded and the detector is held at the start.

The state machine has six states. `ST_IDLE` means no step has matched. `ST_GOT1` to `ST_GOT5` mean that many prefix reads have matched. The transitions are:

- **advance**: a read that matches the next prefix address moves one state forward.
- **restart**: a mismatching read at the first prefix address goes to `ST_GOT1`.
- **abort**: any other mismatching read, or any write, goes to `ST_IDLE`.
- **fire**: from `ST_GOT5`, a read at the save or restore address goes to `ST_IDLE` and issues the pulse.
- **freeze**: `busy` forces `ST_IDLE`.
- **hold**: a cycle with no access keeps the current state.

Top module: `seqcmd_detect`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `save_pulse` and `restore_pulse` are low and the detector is in `ST_IDLE`.
- R2: Six reads to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0, in that order, raise `save_pulse` for exactly one cycle. The pulse is high in the cycle after the clock edge that samples the sixth strobe.
- R3: The same five prefix reads followed by a read at 0x0C63 raise `restore_pulse` for exactly one cycle, with the same timing as R2.
- R4: A read at any address other than the expected next one aborts the pattern. A command address read without the complete prefix before it issues no pulse.
- R5: A write (`bus_we`=1) at any step aborts the pattern, even if it targets the expected address, and no pulse is issued.
- R6: The level of `bus_oe` has no effect; a pattern read with `bus_oe` low still counts.
- R7: A read at 0x0E38 that breaks the pattern at any step, including in place of the sixth read, counts as the first step. The next five reads can then complete a command.
- R8: When `busy` is high in a cycle, that cycle's access is ignored and the detector returns to `ST_IDLE`. Prefix reads already made are lost.
- R9: An access counts once, in the cycle its strobe is sampled high with `bus_sel`=1. Cycles without a strobe, and strobes with `bus_sel`=0, change nothing, however long `bus_sel` stays high.
- R10: `save_pulse` and `restore_pulse` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Chip select, active high |
| bus_we | input | 1 | Write enable, 1 = write access |
| bus_oe | input | 1 | Output enable, ignored by the decoder |
| bus_addr | input | 15 | Access address |
| bus_stb | input | 1 | One-cycle strobe marking an access |
| busy | input | 1 | Command in progress; freezes detection |
| save_pulse | output | 1 | One-cycle save command |
| restore_pulse | output | 1 | One-cycle restore command |

## Verification
An abort and a restart can happen on the same access: a mismatching read at 0x0E38 both breaks the current pattern and begins a new one. The bench provokes this in the middle of the prefix and again in the sixth slot. It is judged by whether a later, shorter run of five reads produces the expected pulse in the expected cycle. A freeze can also land on an access that would have been a valid step. The bench drives a strobed prefix read together with `busy`, completes the rest of the pattern, and requires that no pulse appears.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    localparam int ADDR_W     = 15;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ_DRV,
        ACC_READ_QUIET,
        ACC_WRITE
    } acc_kind_e;

    typedef enum logic [STEP_W-1:0] {
        ST_IDLE = 3'd0,
        ST_GOT1 = 3'd1,
        ST_GOT2 = 3'd2,
        ST_GOT3 = 3'd3,
        ST_GOT4 = 3'd4,
        ST_GOT5 = 3'd5
    } step_e;

    localparam addr_t SAVE_ADDR    = 15'h0FC0;
    localparam addr_t RESTORE_ADDR = 15'h0C63;

    function automatic addr_t prefix_addr(input int idx);
        addr_t a;
        case (idx)
            0:       a = 15'h0E38;
            1:       a = 15'h31C7;
            2:       a = 15'h03E0;
            3:       a = 15'h3C1F;
            default: a = 15'h303F;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/seqcmd_access_qual.sv
module seqcmd_access_qual
    import seqcmd_pkg::*;
(
    input  logic      sel,
    input  logic      we,
    input  logic      oe,
    input  logic      stb,
    input  logic      busy,
    output acc_kind_e kind
);

    logic live;

    assign live = stb && sel && !busy;

    always_comb begin
        if (!live)
            kind = ACC_NONE;
        else if (we)
            kind = ACC_WRITE;
        else if (oe)
            kind = ACC_READ_DRV;
        else
            kind = ACC_READ_QUIET;
    end

endmodule

// File: rtl/seqcmd_addr_match.sv
module seqcmd_addr_match
    import seqcmd_pkg::*;
#(
    parameter int N_PREFIX = PREFIX_LEN
) (
    input  addr_t               addr,
    output logic [N_PREFIX-1:0] hit_prefix,
    output logic                hit_save,
    output logic                hit_restore
);

    for (genvar g = 0; g < N_PREFIX; g++) begin : g_cmp
        localparam addr_t KEY = prefix_addr(g);
        assign hit_prefix[g] = (addr == KEY);
    end

    assign hit_save    = (addr == SAVE_ADDR);
    assign hit_restore = (addr == RESTORE_ADDR);

endmodule

// File: rtl/seqcmd_fsm.sv
module seqcmd_fsm
    import seqcmd_pkg::*;
#(
    parameter int N_PREFIX = PREFIX_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  acc_kind_e           kind,
    input  logic                busy,
    input  logic [N_PREFIX-1:0] hit_prefix,
    input  logic                hit_save,
    input  logic                hit_restore,
    output logic                save_pulse,
    output logic                restore_pulse
);

    step_e state, state_nx;
    logic  fire_save, fire_restore;
    logic  is_read;
    int    idx;

    assign is_read = (kind == ACC_READ_DRV) || (kind == ACC_READ_QUIET);
    assign idx     = int'(state);

    always_comb begin
        state_nx     = state;
        fire_save    = 1'b0;
        fire_restore = 1'b0;
        if (busy) begin
            state_nx = ST_IDLE;
        end else if (kind == ACC_WRITE) begin
            state_nx = ST_IDLE;
        end else if (is_read) begin
            unique case (state)
                ST_IDLE, ST_GOT1, ST_GOT2, ST_GOT3, ST_GOT4: begin
                    if (hit_prefix[idx])
                        state_nx = step_e'(STEP_W'(idx + 1));
                    else if (hit_prefix[0])
                        state_nx = ST_GOT1;
                    else
                        state_nx = ST_IDLE;
                end
                ST_GOT5: begin
                    if (hit_save) begin
                        state_nx  = ST_IDLE;
                        fire_save = 1'b1;
                    end else if (hit_restore) begin
                        state_nx     = ST_IDLE;
                        fire_restore = 1'b1;
                    end else if (hit_prefix[0]) begin
                        state_nx = ST_GOT1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            save_pulse    <= 1'b0;
            restore_pulse <= 1'b0;
        end else begin
            save_pulse    <= fire_save;
            restore_pulse <= fire_restore;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE) && !save_pulse && !restore_pulse);

    p_save_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        save_pulse |-> $past((state == ST_GOT5) && is_read && hit_save && !busy));

    p_restore_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restore_pulse |-> $past((state == ST_GOT5) && is_read && hit_restore && !busy));

    p_write_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WRITE) |=> (state == ST_IDLE) && !save_pulse && !restore_pulse);

    p_busy_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state == ST_IDLE) && !save_pulse && !restore_pulse);

    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_NONE) && !busy |=> $stable(state));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_pulse, restore_pulse}));

    p_single_save_r10: assert property (@(posedge clk) disable iff (!rst_n)
        save_pulse |=> !save_pulse);

    p_single_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restore_pulse |=> !restore_pulse);

endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
    import seqcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_oe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_stb,
    input  logic              busy,
    output logic              save_pulse,
    output logic              restore_pulse
);

    acc_kind_e             kind;
    logic [PREFIX_LEN-1:0] hit_prefix;
    logic                  hit_save;
    logic                  hit_restore;

    seqcmd_access_qual u_qual (
        .sel  (bus_sel),
        .we   (bus_we),
        .oe   (bus_oe),
        .stb  (bus_stb),
        .busy (busy),
        .kind (kind)
    );

    seqcmd_addr_match #(.N_PREFIX(PREFIX_LEN)) u_match (
        .addr        (bus_addr),
        .hit_prefix  (hit_prefix),
        .hit_save    (hit_save),
        .hit_restore (hit_restore)
    );

    seqcmd_fsm #(.N_PREFIX(PREFIX_LEN)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .kind          (kind),
        .busy          (busy),
        .hit_prefix    (hit_prefix),
        .hit_save      (hit_save),
        .hit_restore   (hit_restore),
        .save_pulse    (save_pulse),
        .restore_pulse (restore_pulse)
    );

endmodule

// File: tb/sim_seqcmd_detect.sv
module sim_seqcmd_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, bus_oe = 1'b0, bus_stb = 1'b0, busy = 1'b0;
    logic [14:0] bus_addr = '0;
    logic        save_pulse, restore_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        bit    is_save;
        int    when;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    localparam logic [14:0] K0 = 15'h0E38, K1 = 15'h31C7, K2 = 15'h03E0,
                            K3 = 15'h3C1F, K4 = 15'h303F;
    localparam logic [14:0] A_SAVE = 15'h0FC0, A_REST = 15'h0C63;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    seqcmd_detect u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .bus_stb(bus_stb), .busy(busy),
        .save_pulse(save_pulse), .restore_pulse(restore_pulse)
    );

    // monitor: pops the scoreboard whenever a pulse is seen
    always @(negedge clk) begin
        if (rst_n && (save_pulse || restore_pulse)) begin
            checks++;
            if (save_pulse && restore_pulse) begin
                errors++;
                $display("FAIL R10: both pulses high at cycle %0d, expected at most one", cyc);
            end else if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4: unexpected %s pulse at cycle %0d, expected none",
                         save_pulse ? "save" : "restore", cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_save != save_pulse || e.when != cyc) begin
                    errors++;
                    $display("FAIL %s: got %s at cycle %0d, expected %s at cycle %0d", e.tag,
                             save_pulse ? "save" : "restore", cyc,
                             e.is_save ? "save" : "restore", e.when);
                end
            end
        end
    end

    task automatic access(input logic sel, input logic we, input logic oe,
                          input logic [14:0] a, input logic bz = 1'b0);
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_oe = oe; bus_addr = a; busy = bz; bus_stb = 1'b1;
        @(negedge clk);
        bus_stb = 1'b0; busy = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, input logic oe = 1'b1);
        access(1'b1, 1'b0, oe, a);
    endtask

    task automatic rd_expect(input logic [14:0] a, input bit is_save, input string tag,
                             input logic oe = 1'b1);
        exp_t e;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_oe = oe; bus_addr = a; bus_stb = 1'b1;
        e.is_save = is_save; e.when = cyc + 1; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_stb = 1'b0;
    endtask

    task automatic prefix(input int n, input logic oe = 1'b1);
        logic [14:0] keys [5];
        keys = '{K0, K1, K2, K3, K4};
        for (int i = 0; i < n; i++) rd(keys[i], oe);
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected pulse(s) missing, expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (save_pulse !== 1'b0 || restore_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: pulses %b%b in reset, expected 00", save_pulse, restore_pulse);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (save_pulse !== 1'b0 || restore_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: pulses %b%b after reset, expected 00", save_pulse, restore_pulse);
        end

        // R2 save
        prefix(5); rd_expect(A_SAVE, 1'b1, "R2");
        drain("R2");
        // R3 restore
        prefix(5); rd_expect(A_REST, 1'b0, "R3");
        drain("R3");
        // R4 wrong address at step four, then remaining steps: nothing
        prefix(3); rd(15'h1234); rd(K4); rd(A_SAVE);
        drain("R4");
        // R4 command address without full prefix
        prefix(4); rd(A_REST);
        drain("R4");
        // R5 write to the expected address aborts
        prefix(2); access(1'b1, 1'b1, 1'b0, K2); rd(K3); rd(K4); rd(A_SAVE);
        drain("R5");
        // R5 write in sixth slot
        prefix(5); access(1'b1, 1'b1, 1'b0, A_SAVE); rd(A_SAVE);
        drain("R5");
        // R6 output enable low throughout
        prefix(5, 1'b0); rd_expect(A_REST, 1'b0, "R6", 1'b0);
        drain("R6");
        // R7 restart mid prefix (abort and restart in one access)
        prefix(3); rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd_expect(A_SAVE, 1'b1, "R7");
        drain("R7");
        // R7 restart in the sixth slot
        prefix(5); rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd_expect(A_REST, 1'b0, "R7");
        drain("R7");
        // R8 busy without access drops progress
        prefix(3);
        @(negedge clk); busy = 1'b1; @(negedge clk); busy = 1'b0;
        rd(K3); rd(K4); rd(A_SAVE);
        drain("R8");
        // R8 strobed first step under busy is ignored
        access(1'b1, 1'b0, 1'b1, K0, 1'b1); prefix(5); rd_expect(A_SAVE, 1'b1, "R8");
        drain("R8");
        access(1'b1, 1'b0, 1'b1, K0, 1'b1); rd(K1); rd(K2); rd(K3); rd(K4); rd(A_SAVE);
        drain("R8");
        // R9 long select with gaps, deselected strobes in between
        @(negedge clk); bus_sel = 1'b1; bus_addr = 15'h7FFF;
        repeat (4) @(negedge clk);
        rd(K0); repeat (5) @(negedge clk);
        access(1'b0, 1'b0, 1'b1, 15'h5555);
        access(1'b0, 1'b1, 1'b0, K1);
        rd(K1); rd(K2); repeat (2) @(negedge clk);
        rd(K3); rd(K4);
        access(1'b0, 1'b0, 1'b1, 15'h0000);
        rd_expect(A_SAVE, 1'b1, "R9");
        drain("R9");
        // R9 held address with one strobe counts once
        @(negedge clk); bus_sel = 1'b1; bus_addr = K0; repeat (3) @(negedge clk);
        rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd_expect(A_SAVE, 1'b1, "R9");
        drain("R9");
        // R10 back to back commands stay single pulses
        prefix(5); rd_expect(A_SAVE, 1'b1, "R10");
        prefix(5); rd_expect(A_REST, 1'b0, "R10");
        drain("R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule